// File: doc/BRIEF.md
# Priority-Aware Cache Way Victim Selector

This block picks the way a newly fetched cacheable line should fill in a set-associative instruction cache, and keeps the replacement state for every set. That state is a valid flag, an importance flag (high or low) and an LRU age for each way. The cache controller presents a set index together with the fill request's importance. In the same cycle the block answers with a victim way and an allocate flag. When allocate is low, the fetched line is still passed to the core but is not written into the cache.

A high line may displace a low line, but a low line may never displace a high one. A per-way lock mask takes ways out of the choice entirely, so the contents of a locked way leave only through an explicit invalidate or a full flush. A demotion strobe turns every high line in the cache into a low line in one cycle. Hits refresh LRU order. Single-way invalidates and a global flush clear the state. The tag and data arrays, tag comparison and the refill bus belong to the surrounding controller.

Top module: `way_victim_sel`

## Requirements
- R1: For any fill, if an unlocked way of the addressed set is unoccupied, the victim is the lowest-numbered such way and allocate is 1.
- R2: A high fill with no unlocked unoccupied way takes the least recently used unlocked low way.
- R3: A high fill whose unlocked ways all hold high lines takes the least recently used of them.
- R4: A low fill takes an unlocked unoccupied way if one exists, otherwise the least recently used unlocked low way, and never a high line.
- R5: A low fill whose unlocked ways all hold high lines sees allocate 0 and changes no state.
- R6: A locked way is never the victim. When all ways are locked, allocate is 0 and a fill changes no state.
- R7: With lock mask 4'b1110, every allocating fill chooses way 0.
- R8: LRU age is 2 bits per way, and ways start at age equal to the way number. An allocating fill or a hit sets the touched way to age 0 and increments every way that was younger than it.
- R9: A demotion strobe makes every high line low at the next clock edge. A fill in the same cycle still records its own importance.
- R10: Invalidating a way clears its valid and importance flags, even when the way is locked.
- R11: A global flush clears every valid and importance flag and returns all ages to the reset order within one cycle. It overrides every other command in that cycle.
- R12: After reset every line is unoccupied, so with no locks the outputs are victim 0 and allocate 1.
- R13: Within one cycle, a fill request takes precedence over an invalidate, which takes precedence over a hit. A fill that does not allocate still suppresses the other two commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| set_i | input | SET_W | Set addressed by this cycle's fill, hit or invalidate |
| fill_req_i | input | 1 | Fill request for a fetched cacheable line |
| fill_high_i | input | 1 | Importance of the line being fetched (1 = high) |
| hit_i | input | 1 | Hit on way hit_way_i of set_i |
| hit_way_i | input | WAY_W | Way that hit |
| inv_i | input | 1 | Invalidate way inv_way_i of set_i |
| inv_way_i | input | WAY_W | Way to invalidate |
| flush_all_i | input | 1 | Invalidate the whole cache |
| prio_rst_i | input | 1 | Demote every high line to low |
| lock_i | input | NUM_WAYS | Per-way lock mask |
| victim_way_o | output | WAY_W | Chosen way (0 when allocate is 0) |
| alloc_o | output | 1 | The fetched line may be cached in victim_way_o |

## Verification
Victim and allocate are combinational in set_i, fill_high_i, lock_i and the stored state. They are due in the same cycle as the stimulus, so the bench samples them a quarter period before the rising edge. Commands update the state at the rising edge that ends their cycle. Their effect on victim choice therefore first appears in the next cycle's sample. The reference model is advanced at the edge in the same order.

// File: rtl/way_repl_pkg.sv
package way_repl_pkg;
  typedef enum logic [1:0] {OP_IDLE, OP_FILL, OP_INV, OP_HIT} set_op_e;
endpackage

// File: rtl/way_lru_ages.sv
module way_lru_ages #(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 64,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int AGE_W = WAY_W
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             clear_i,
  input  logic                             touch_i,
  input  logic [SET_W-1:0]                 set_i,
  input  logic [WAY_W-1:0]                 way_i,
  output logic [NUM_WAYS-1:0][AGE_W-1:0]   ages_o
);
  logic [NUM_WAYS-1:0][AGE_W-1:0] age_q [NUM_SETS];
  logic [NUM_WAYS-1:0][AGE_W-1:0] row_nxt;
  logic [AGE_W-1:0]               old_age;

  assign ages_o  = age_q[set_i];
  assign old_age = ages_o[way_i];

  always_comb begin
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (WAY_W'(w) == way_i)          row_nxt[w] = '0;
      else if (ages_o[w] < old_age)    row_nxt[w] = ages_o[w] + AGE_W'(1);
      else                             row_nxt[w] = ages_o[w];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int w = 0; w < NUM_WAYS; w++)
          age_q[s][w] <= AGE_W'(w);
    end else if (clear_i) begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int w = 0; w < NUM_WAYS; w++)
          age_q[s][w] <= AGE_W'(w);
    end else if (touch_i) begin
      age_q[set_i] <= row_nxt;
    end
  end
endmodule

// File: rtl/way_line_flags.sv
module way_line_flags #(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 64,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int SET_W = $clog2(NUM_SETS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                demote_i,
  input  logic                fill_i,
  input  logic                fill_high_i,
  input  logic [WAY_W-1:0]    fill_way_i,
  input  logic                inv_i,
  input  logic [WAY_W-1:0]    inv_way_i,
  input  logic [SET_W-1:0]    set_i,
  output logic [NUM_WAYS-1:0] valid_o,
  output logic [NUM_WAYS-1:0] high_o
);
  logic [NUM_WAYS-1:0] valid_q [NUM_SETS];
  logic [NUM_WAYS-1:0] high_q  [NUM_SETS];

  assign valid_o = valid_q[set_i];
  assign high_o  = high_q[set_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        valid_q[s] <= '0;
        high_q[s]  <= '0;
      end
    end else if (clear_i) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        valid_q[s] <= '0;
        high_q[s]  <= '0;
      end
    end else begin
      if (demote_i)
        for (int s = 0; s < NUM_SETS; s++) high_q[s] <= '0;
      // fill importance is written after demotion so it survives
      if (fill_i) begin
        valid_q[set_i][fill_way_i] <= 1'b1;
        high_q[set_i][fill_way_i]  <= fill_high_i;
      end else if (inv_i) begin
        valid_q[set_i][inv_way_i]  <= 1'b0;
        high_q[set_i][inv_way_i]   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/way_victim_pick.sv
module way_victim_pick #(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int AGE_W = WAY_W
) (
  input  logic [NUM_WAYS-1:0]            valid_i,
  input  logic [NUM_WAYS-1:0]            high_i,
  input  logic [NUM_WAYS-1:0][AGE_W-1:0] ages_i,
  input  logic [NUM_WAYS-1:0]            lock_i,
  input  logic                           fill_high_i,
  output logic [WAY_W-1:0]               way_o,
  output logic                           alloc_o
);
  logic [NUM_WAYS-1:0] empty_m, low_m, high_m;
  logic [WAY_W:0]      empty_sel, low_sel, high_sel;

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_mask
    assign empty_m[g] = !lock_i[g] && !valid_i[g];
    assign low_m[g]   = !lock_i[g] &&  valid_i[g] && !high_i[g];
    assign high_m[g]  = !lock_i[g] &&  valid_i[g] &&  high_i[g] && fill_high_i;
  end

  function automatic logic [WAY_W:0] lowest(input logic [NUM_WAYS-1:0] m);
    logic [WAY_W:0] r;
    r = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--)
      if (m[i]) r = {1'b1, WAY_W'(i)};
    return r;
  endfunction

  function automatic logic [WAY_W:0] oldest(input logic [NUM_WAYS-1:0] m,
                                            input logic [NUM_WAYS-1:0][AGE_W-1:0] a);
    logic             found;
    logic [AGE_W-1:0] best;
    logic [WAY_W-1:0] bw;
    found = 1'b0;
    best  = '0;
    bw    = '0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (m[i] && (!found || a[i] > best)) begin
        found = 1'b1;
        best  = a[i];
        bw    = WAY_W'(i);
      end
    end
    return {found, bw};
  endfunction

  assign empty_sel = lowest(empty_m);
  assign low_sel   = oldest(low_m, ages_i);
  assign high_sel  = oldest(high_m, ages_i);

  always_comb begin
    if (empty_sel[WAY_W])     {alloc_o, way_o} = empty_sel;
    else if (low_sel[WAY_W])  {alloc_o, way_o} = low_sel;
    else if (high_sel[WAY_W]) {alloc_o, way_o} = high_sel;
    else                      {alloc_o, way_o} = '0;
  end
endmodule

// File: rtl/way_victim_sel.sv
module way_victim_sel
  import way_repl_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 64,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int AGE_W = WAY_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SET_W-1:0]    set_i,
  input  logic                fill_req_i,
  input  logic                fill_high_i,
  input  logic                hit_i,
  input  logic [WAY_W-1:0]    hit_way_i,
  input  logic                inv_i,
  input  logic [WAY_W-1:0]    inv_way_i,
  input  logic                flush_all_i,
  input  logic                prio_rst_i,
  input  logic [NUM_WAYS-1:0] lock_i,
  output logic [WAY_W-1:0]    victim_way_o,
  output logic                alloc_o
);
  set_op_e                        op;
  logic [NUM_WAYS-1:0]            set_valid, set_high;
  logic [NUM_WAYS-1:0][AGE_W-1:0] set_ages;
  logic                           fill_wr, touch_en;
  logic [WAY_W-1:0]               touch_way;

  always_comb begin
    if (fill_req_i)  op = OP_FILL;
    else if (inv_i)  op = OP_INV;
    else if (hit_i)  op = OP_HIT;
    else             op = OP_IDLE;
  end

  assign fill_wr   = (op == OP_FILL) && alloc_o;
  assign touch_en  = fill_wr || (op == OP_HIT);
  assign touch_way = (op == OP_FILL) ? victim_way_o : hit_way_i;

  way_lru_ages #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) u_ages (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (flush_all_i),
    .touch_i (touch_en),
    .set_i   (set_i),
    .way_i   (touch_way),
    .ages_o  (set_ages)
  );

  way_line_flags #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (flush_all_i),
    .demote_i    (prio_rst_i),
    .fill_i      (fill_wr),
    .fill_high_i (fill_high_i),
    .fill_way_i  (victim_way_o),
    .inv_i       (op == OP_INV),
    .inv_way_i   (inv_way_i),
    .set_i       (set_i),
    .valid_o     (set_valid),
    .high_o      (set_high)
  );

  way_victim_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
    .valid_i     (set_valid),
    .high_i      (set_high),
    .ages_i      (set_ages),
    .lock_i      (lock_i),
    .fill_high_i (fill_high_i),
    .way_o       (victim_way_o),
    .alloc_o     (alloc_o)
  );
endmodule

// File: rtl/way_victim_sel_chk.sv
module way_victim_sel_chk #(
  parameter int NUM_WAYS = 4,
  parameter int WAY_W = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                fill_req_i,
  input logic                fill_high_i,
  input logic                flush_all_i,
  input logic [NUM_WAYS-1:0] lock_i,
  input logic [WAY_W-1:0]    victim_way_o,
  input logic                alloc_o,
  input logic [NUM_WAYS-1:0] cur_valid,
  input logic [NUM_WAYS-1:0] cur_high
);
  AST_LOCKED_NEVER_VICTIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_o |-> !lock_i[victim_way_o]); // R6

  AST_ALL_LOCKED_NO_ALLOC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&lock_i) |-> !alloc_o); // R6

  AST_UPPER_LOCKED_WAY0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_o && (&lock_i[NUM_WAYS-1:1])) |-> (victim_way_o == '0)); // R7

  AST_LOW_SPARES_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_i && !fill_high_i && alloc_o) |->
      !(cur_valid[victim_way_o] && cur_high[victim_way_o])); // R4

  AST_EMPTY_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_i && alloc_o && |(~lock_i & ~cur_valid)) |-> !cur_valid[victim_way_o]); // R1

  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_i |=> (cur_valid == '0 && cur_high == '0)); // R11
endmodule

bind way_victim_sel way_victim_sel_chk #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fill_req_i   (fill_req_i),
  .fill_high_i  (fill_high_i),
  .flush_all_i  (flush_all_i),
  .lock_i       (lock_i),
  .victim_way_o (victim_way_o),
  .alloc_o      (alloc_o),
  .cur_valid    (set_valid),
  .cur_high     (set_high)
);

// File: tb/way_victim_sel_bench.sv
module way_victim_sel_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 4;
  localparam int NS = 64;
  localparam int WW = 2;
  localparam int SW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [SW-1:0] set_i = '0;
  logic          fill_req = 1'b0, fill_high = 1'b0, hit = 1'b0, inv = 1'b0;
  logic [WW-1:0] hit_way = '0, inv_way = '0;
  logic          flush = 1'b0, prio = 1'b0;
  logic [NW-1:0] lock = '0;
  logic [WW-1:0] victim;
  logic          alloc;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  bit m_valid [NS][NW];
  bit m_high  [NS][NW];
  int m_age   [NS][NW];

  always #(CLK_PERIOD/2) clk = ~clk;

  way_victim_sel u_way_victim_sel (
    .clk_i(clk), .rst_ni(rst_n), .set_i(set_i), .fill_req_i(fill_req),
    .fill_high_i(fill_high), .hit_i(hit), .hit_way_i(hit_way), .inv_i(inv),
    .inv_way_i(inv_way), .flush_all_i(flush), .prio_rst_i(prio), .lock_i(lock),
    .victim_way_o(victim), .alloc_o(alloc)
  );

  function automatic void model_reset();
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        m_valid[s][w] = 1'b0;
        m_high[s][w]  = 1'b0;
        m_age[s][w]   = w;
      end
  endfunction

  function automatic void touch(int s, int w);
    int old;
    old = m_age[s][w];
    for (int i = 0; i < NW; i++)
      if (i == w) m_age[s][i] = 0;
      else if (m_age[s][i] < old) m_age[s][i]++;
  endfunction

  // {alloc, way} from the replacement rules
  function automatic logic [2:0] exp_pick(int s, bit hi, logic [NW-1:0] lk);
    int best;
    for (int w = 0; w < NW; w++)
      if (!lk[w] && !m_valid[s][w]) return {1'b1, 2'(w)};
    best = -1;
    for (int w = 0; w < NW; w++)
      if (!lk[w] && m_valid[s][w] && !m_high[s][w] && (best < 0 || m_age[s][w] > m_age[s][best]))
        best = w;
    if (best >= 0) return {1'b1, 2'(best)};
    if (hi)
      for (int w = 0; w < NW; w++)
        if (!lk[w] && m_valid[s][w] && m_high[s][w] && (best < 0 || m_age[s][w] > m_age[s][best]))
          best = w;
    if (best >= 0) return {1'b1, 2'(best)};
    return 3'b000;
  endfunction

  function automatic string tag_of(int s, bit hi, logic [NW-1:0] lk);
    bit emp, low;
    emp = 0; low = 0;
    for (int w = 0; w < NW; w++) begin
      if (!lk[w] && !m_valid[s][w]) emp = 1;
      if (!lk[w] && m_valid[s][w] && !m_high[s][w]) low = 1;
    end
    if (&lk) return "R6";
    if (lk == 4'b1110) return "R7";
    if (emp) return "R1";
    if (hi) return low ? "R2" : "R3";
    return low ? "R4" : "R5";
  endfunction

  task automatic step(string tag, bit f, bit hi, bit h, int hw, bit iv, int iw,
                      int s, logic [NW-1:0] lk, bit pr, bit fl);
    logic [2:0] exp;
    fill_req = f; fill_high = hi; hit = h; hit_way = WW'(hw); inv = iv;
    inv_way = WW'(iw); set_i = SW'(s); lock = lk; prio = pr; flush = fl;
    #(CLK_PERIOD/4);
    exp = exp_pick(s, hi, lk);
    n_checks++;
    if ({alloc, victim} !== exp) begin
      n_fail++;
      $display("FAIL %s: set %0d alloc/way actual %b/%0d expected %b/%0d",
               tag, s, alloc, victim, exp[2], exp[1:0]);
    end
    @(posedge clk);
    if (fl) model_reset();
    else begin
      if (pr)
        for (int a = 0; a < NS; a++)
          for (int w = 0; w < NW; w++) m_high[a][w] = 1'b0;
      if (f) begin
        if (exp[2]) begin
          m_valid[s][exp[1:0]] = 1'b1;
          m_high[s][exp[1:0]]  = hi;
          touch(s, int'(exp[1:0]));
        end
      end else if (iv) begin
        m_valid[s][iw] = 1'b0;
        m_high[s][iw]  = 1'b0;
      end else if (h) touch(s, hw);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: all requirements, actual still running, expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    step("R12", 0,0,0,0,0,0, 0, 4'b0000, 0,0);
    for (int i = 0; i < 4; i++) step("R1", 1,1,0,0,0,0, 0, 4'b0000, 0,0);
    step("R3", 1,1,0,0,0,0, 0, 4'b0000, 0,0);
    step("R5", 1,0,0,0,0,0, 0, 4'b0000, 0,0);
    step("R5", 0,1,0,0,0,0, 0, 4'b0000, 0,0);
    step("R9", 0,0,0,0,0,0, 0, 4'b0000, 1,0);
    step("R9", 1,0,0,0,0,0, 0, 4'b0000, 0,0);
    step("R8", 0,1,1,2,0,0, 0, 4'b0000, 0,0);
    step("R8", 0,1,0,0,0,0, 0, 4'b0000, 0,0);
    step("R2", 1,1,0,0,0,0, 0, 4'b0000, 0,0);
    step("R7", 1,0,0,0,0,0, 0, 4'b1110, 0,0);
    step("R6", 1,1,0,0,0,0, 0, 4'b1111, 0,0);
    step("R10", 0,1,0,0,1,2, 0, 4'b1111, 0,0);
    step("R10", 0,1,0,0,0,0, 0, 4'b1111, 0,0);
    step("R10", 0,0,0,0,0,0, 0, 4'b0000, 0,0);
    step("R13", 1,1,1,1,1,3, 0, 4'b0000, 0,0);
    step("R13", 0,1,0,0,0,0, 0, 4'b0000, 0,0);
    step("R11", 0,0,0,0,0,0, 0, 4'b0000, 0,1);
    step("R11", 0,0,0,0,0,0, 0, 4'b0000, 0,0);
    step("R4", 1,0,0,0,0,0, 0, 4'b0000, 0,0);

    for (int n = 0; n < 4000; n++) begin
      int s; bit hi; logic [NW-1:0] lk; int r;
      s  = int'($urandom_range(0, 3));
      hi = 1'($urandom_range(0, 1));
      lk = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'b0000;
      r  = int'($urandom_range(0, 9));
      step(tag_of(s, hi, lk), r < 5, hi, r >= 5 && r < 8, int'($urandom_range(0,3)),
           r >= 8 || ($urandom_range(0,7) == 0), int'($urandom_range(0,3)), s, lk,
           $urandom_range(0,31) == 0, $urandom_range(0,299) == 0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule